// File: doc/BRIEF.md
# Multi-Speed Data-Strobe Transmit Serializer

This block takes packet data from a link-layer controller and turns it into a serial data/strobe pair for one cable port. The link side delivers one parallel word on every cycle of the system clock. The requested speed sets how many lanes of that word carry payload: 2 lanes for S100, 4 for S200 and 8 for S400. Because the word rate is the same at every speed, the serial rate is 98.304, 196.608 or 393.216 Mbit/s.

Serial bit timing comes from a fast bit clock at eight times the system clock, which is the divided high-speed reference. A bit-rate enable inside the block fires on every fourth, every second or every fast-clock cycle. The bits of each word go out most significant first.

The encoded data stream is meant for the B pair and the encoded strobe stream for the A pair. Both outputs rest low between packets. Each new packet is encoded against a cleared line state.

Top module: `ds_tx_serializer`

## Requirements
- R1: The bits sent come from the high end of `txData`. S100 (code 0) uses `txData[7:6]`, S200 (code 1) uses `txData[7:4]` and S400 (code 2) uses `txData[7:0]`. Within each word the most significant bit goes first, and no other lane is sent.
- R2: One serial bit lasts 4 fast-clock cycles at S100, 2 at S200 and 1 at S400. Consecutive words of a packet follow without gaps. A packet of N words sends exactly N times the lane count in bits.
- R3: `dsData` carries the current bit. `dsStrobe` toggles only when the new bit equals the previous one. At every bit boundary exactly one of the two lines changes.
- R4: After reset and whenever no packet word is being sent, both `dsData` and `dsStrobe` are 0.
- R5: The first bit of every packet is encoded against a cleared line state. A first bit of 1 gives data=1 and strobe=0. A first bit of 0 gives data=0 and strobe=1.
- R6: `speedSel` is taken in the system-clock cycle where `txValid` rises. Later changes of `speedSel` during the packet have no effect on bit timing or lane count.
- R7: Speed code 3 behaves exactly as S400.
- R8: Between bit boundaries of an active packet, `dsData` and `dsStrobe` hold steady.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkSys | input | 1 | System clock; link data and controls are sampled on its rising edge |
| clkBit | input | 1 | Fast bit clock at eight times `clkSys`, phase-related to it |
| rstN | input | 1 | Asynchronous active-low reset for both clock domains |
| txValid | input | 1 | High while packet words are presented |
| speedSel | input | 2 | Speed code: 0 S100, 1 S200, 2 S400, 3 treated as S400 |
| txData | input | 8 | Parallel link word; the used lanes depend on the speed |
| dsData | output | 1 | Encoded data line, toward the B pair |
| dsStrobe | output | 1 | Encoded strobe line, toward the A pair |

## Verification
Some properties are checked on every cycle by assertions:
- each bit step changes exactly one line;
- the outputs hold steady between steps;
- the outputs go low when no packet word is active;
- the latched speed stays fixed while `txValid` stays high;
- word loads in the fast domain arrive exactly eight fast cycles apart.

Other properties only the bench scenarios can show. The bench decodes the line pair back into bits, so it shows:
- the lane selection and the most-significant-first order;
- the per-speed bit spacing;
- the first-bit encoding against a cleared state;
- that a speed change in mid-packet and the reserved code 3 behave as required.

// File: rtl/ds_tx_pkg.sv
package ds_tx_pkg;

  parameter int unsigned DS_LANES = 8;
  localparam int unsigned IDX_W = $clog2(DS_LANES);

  typedef enum logic [1:0] {
    SPD_S100 = 2'd0,
    SPD_S200 = 2'd1,
    SPD_S400 = 2'd2,
    SPD_RSVD = 2'd3
  } speed_e;

  // strobes from control to datapath, all in the bit-clock domain
  typedef struct packed {
    logic             loadWord;   // take the next system word
    logic             bitStep;    // emit one serial bit now
    logic [IDX_W-1:0] bitIdx;     // position from the MSB of that bit
    logic             wordActive; // current word belongs to a packet
  } ds_ctrl_s;

endpackage

// File: rtl/ds_tx_ctrl.sv
module ds_tx_ctrl
  import ds_tx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clkSys,
  input  logic       clkBit,
  input  logic       rstN,
  input  logic       txValid,
  input  logic [1:0] speedSel,
  output ds_ctrl_s   ctrl
);

  localparam logic [IDX_W-1:0] SLOT_LAST = IDX_W'(DS_LANES - 1);

  // ---------------- system-clock side ----------------
  logic   capValid;
  speed_e speedHeld;
  logic   wordTgl;

  always_ff @(posedge clkSys or negedge rstN) begin
    if (!rstN) begin
      capValid  <= 1'b0;
      speedHeld <= SPD_S400;
      wordTgl   <= 1'b0;
    end else begin
      capValid <= txValid;
      if (txValid && !capValid) speedHeld <= speed_e'(speedSel);
      wordTgl <= ~wordTgl;
    end
  end

  AST_SPEED_HELD: assert property (@(posedge clkSys) disable iff (!rstN)
    (capValid && txValid) |=> $stable(speedHeld)); // R6

  // ---------------- bit-clock side ----------------
  logic [SYNC_STAGES:0] tglSync;
  logic                 loadNow;
  logic [IDX_W-1:0]     slot;
  logic                 activeWord;
  speed_e               speedWord;
  logic                 loadSeen;
  logic [1:0]           shiftAmt;
  logic [IDX_W-1:0]     stepMask;

  always_ff @(posedge clkBit or negedge rstN) begin
    if (!rstN) tglSync <= '0;
    else       tglSync <= {tglSync[SYNC_STAGES-1:0], wordTgl};
  end

  assign loadNow = tglSync[SYNC_STAGES] ^ tglSync[SYNC_STAGES-1];

  always_ff @(posedge clkBit or negedge rstN) begin
    if (!rstN) begin
      slot       <= '0;
      activeWord <= 1'b0;
      speedWord  <= SPD_S400;
      loadSeen   <= 1'b0;
    end else if (loadNow) begin
      slot       <= '0;
      activeWord <= capValid;
      speedWord  <= speedHeld;
      loadSeen   <= 1'b1;
    end else begin
      slot <= slot + 1'b1;
    end
  end

  // the speed picks the bit-rate divider from the fast clock
  always_comb begin
    case (speedWord)
      SPD_S100: shiftAmt = 2'd2;
      SPD_S200: shiftAmt = 2'd1;
      default:  shiftAmt = 2'd0;
    endcase
    stepMask = ~({IDX_W{1'b1}} << shiftAmt);
  end

  assign ctrl.loadWord   = loadNow;
  assign ctrl.bitStep    = activeWord && ((slot & stepMask) == '0);
  assign ctrl.bitIdx     = slot >> shiftAmt;
  assign ctrl.wordActive = activeWord;

  AST_WORD_PERIOD: assert property (@(posedge clkBit) disable iff (!rstN)
    (loadNow && loadSeen) |-> (slot == SLOT_LAST)); // R2

endmodule

// File: rtl/ds_tx_dpath.sv
module ds_tx_dpath
  import ds_tx_pkg::*;
(
  input  logic                clkSys,
  input  logic                clkBit,
  input  logic                rstN,
  input  logic [DS_LANES-1:0] txData,
  input  ds_ctrl_s            ctrl,
  output logic                dsData,
  output logic                dsStrobe
);

  logic [DS_LANES-1:0] capData;
  logic [DS_LANES-1:0] wordReg;
  logic [IDX_W-1:0]    pick;
  logic                serialBit;

  always_ff @(posedge clkSys or negedge rstN) begin
    if (!rstN) capData <= '0;
    else       capData <= txData;
  end

  always_ff @(posedge clkBit or negedge rstN) begin
    if (!rstN)              wordReg <= '0;
    else if (ctrl.loadWord) wordReg <= capData;
  end

  assign pick      = IDX_W'(DS_LANES - 1) - ctrl.bitIdx;
  assign serialBit = wordReg[pick];

  // data/strobe encoder; idle forces both lines low, which also clears the state
  always_ff @(posedge clkBit or negedge rstN) begin
    if (!rstN) begin
      dsData   <= 1'b0;
      dsStrobe <= 1'b0;
    end else if (!ctrl.wordActive) begin
      dsData   <= 1'b0;
      dsStrobe <= 1'b0;
    end else if (ctrl.bitStep) begin
      dsData <= serialBit;
      if (serialBit == dsData) dsStrobe <= ~dsStrobe;
    end
  end

  AST_ONE_TRANSITION: assert property (@(posedge clkBit) disable iff (!rstN)
    ctrl.bitStep |=> ($countones({dsData ^ $past(dsData), dsStrobe ^ $past(dsStrobe)}) == 1)); // R3

  AST_HOLD_BETWEEN_BITS: assert property (@(posedge clkBit) disable iff (!rstN)
    (ctrl.wordActive && !ctrl.bitStep) |=> $stable({dsData, dsStrobe})); // R8

  AST_IDLE_LOW: assert property (@(posedge clkBit) disable iff (!rstN)
    !ctrl.wordActive |=> (!dsData && !dsStrobe)); // R4

endmodule

// File: rtl/ds_tx_serializer.sv
module ds_tx_serializer
  import ds_tx_pkg::*;
(
  input  logic                clkSys,
  input  logic                clkBit,
  input  logic                rstN,
  input  logic                txValid,
  input  logic [1:0]          speedSel,
  input  logic [DS_LANES-1:0] txData,
  output logic                dsData,
  output logic                dsStrobe
);

  ds_ctrl_s ctrlBus;

  ds_tx_ctrl #(.SYNC_STAGES(2)) ctrl_i (
    .clkSys   (clkSys),
    .clkBit   (clkBit),
    .rstN     (rstN),
    .txValid  (txValid),
    .speedSel (speedSel),
    .ctrl     (ctrlBus)
  );

  ds_tx_dpath dpath_i (
    .clkSys   (clkSys),
    .clkBit   (clkBit),
    .rstN     (rstN),
    .txData   (txData),
    .ctrl     (ctrlBus),
    .dsData   (dsData),
    .dsStrobe (dsStrobe)
  );

endmodule

// File: tb/ds_tx_serializer_tb_top.sv
`timescale 1ns/1ps
module ds_tx_serializer_tb_top;

  logic       clkSys = 1'b0;
  logic       clkBit = 1'b0;
  logic       rstN = 1'b0;
  logic       txValid = 1'b0;
  logic [1:0] speedSel = 2'd0;
  logic [7:0] txData = 8'h00;
  logic       dsData;
  logic       dsStrobe;

  int nChecks = 0;
  int nFails  = 0;
  bit monOn   = 1'b0;
  bit doneRun = 1'b0;

  typedef struct {
    logic b;
    int   period;
    bit   first;
    int   tag;
  } exp_t;
  exp_t expQ[$];

  ds_tx_serializer dut_i (
    .clkSys   (clkSys),
    .clkBit   (clkBit),
    .rstN     (rstN),
    .txValid  (txValid),
    .speedSel (speedSel),
    .txData   (txData),
    .dsData   (dsData),
    .dsStrobe (dsStrobe)
  );

  initial forever #4   clkSys = ~clkSys;   // 125 MHz
  initial forever #0.5 clkBit = ~clkBit;   // 8x

  function automatic int periodOf(input logic [1:0] spd);
    return (spd == 2'd0) ? 4 : (spd == 2'd1) ? 2 : 1;
  endfunction

  // driver: presents words and pushes the expected bits into the scoreboard
  task automatic sendPacket(input logic [1:0] spd, input int nWords,
                            input logic [7:0] base, input logic [7:0] stepV,
                            input logic [1:0] disturb, input int tag);
    int lanes;
    int per;
    bit firstBit;
    logic [7:0] w;
    per      = periodOf(spd);
    lanes    = 8 / per;
    firstBit = 1'b1;
    for (int k = 0; k < nWords; k++) begin
      @(negedge clkSys);
      txValid  = 1'b1;
      speedSel = (k == 0) ? spd : disturb;
      w        = base + 8'(k) * stepV;
      txData   = w;
      for (int i = 0; i < lanes; i++) begin
        exp_t e;
        e.b      = w[7 - i];
        e.period = per;
        e.first  = firstBit;
        e.tag    = tag;
        expQ.push_back(e);
        firstBit = 1'b0;
      end
    end
    @(negedge clkSys);
    txValid  = 1'b0;
    txData   = 8'h5A;
    speedSel = disturb;
    while (expQ.size() != 0) @(negedge clkSys);
    repeat (3) @(negedge clkSys);
  endtask

  // monitor: decodes the line pair and compares against the scoreboard
  initial begin
    logic pd;
    logic ps;
    int   gap;
    exp_t e;
    pd  = 1'b0;
    ps  = 1'b0;
    gap = 0;
    forever begin
      @(negedge clkBit);
      if (monOn) begin
        gap++;
        if (dsData !== pd || dsStrobe !== ps) begin
          nChecks++;
          if (expQ.size() == 0) begin
            if (dsData !== 1'b0 || dsStrobe !== 1'b0) begin
              nFails++;
              $display("FAIL R4: idle lines act=%b%b exp=00", dsData, dsStrobe);
            end
          end else begin
            e = expQ.pop_front();
            if ((dsData !== pd) && (dsStrobe !== ps)) begin
              nFails++;
              $display("FAIL R3: both lines changed act=%b%b prev=%b%b", dsData, dsStrobe, pd, ps);
            end
            if (dsData !== e.b) begin
              nFails++;
              $display("FAIL R1: decoded bit act=%b exp=%b (scenario R%0d)", dsData, e.b, e.tag);
            end
            if (e.first) begin
              if (dsStrobe !== ~e.b) begin
                nFails++;
                $display("FAIL R5: first bit pair act=%b%b exp=%b%b", dsData, dsStrobe, e.b, ~e.b);
              end
            end else if (gap != e.period) begin
              nFails++;
              $display("FAIL R2: bit spacing act=%0d exp=%0d (scenario R%0d)", gap, e.period, e.tag);
            end
          end
          gap = 0;
        end
        pd = dsData;
        ps = dsStrobe;
      end
    end
  end

  initial begin
    #200000;
    nFails++;
    $display("FAIL watchdog: act=running exp=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #20.25;
    rstN = 1'b1;
    repeat (4) @(negedge clkSys);
    // R4: reset state
    nChecks++;
    if (dsData !== 1'b0 || dsStrobe !== 1'b0) begin
      nFails++;
      $display("FAIL R4: after reset act=%b%b exp=00", dsData, dsStrobe);
    end
    monOn = 1'b1;

    sendPacket(2'd2, 3, 8'hA5, 8'h11, 2'd2, 1);  // R1 S400 mixed
    sendPacket(2'd1, 4, 8'h3C, 8'h5A, 2'd0, 6);  // R6 speed disturbed to S100
    sendPacket(2'd0, 5, 8'hC0, 8'h40, 2'd2, 1);  // R1 S100 lanes 7:6
    sendPacket(2'd2, 2, 8'h00, 8'h00, 2'd0, 3);  // R3 repeated zeros
    sendPacket(2'd0, 3, 8'hFF, 8'h00, 2'd1, 3);  // R3 repeated ones
    sendPacket(2'd3, 2, 8'h96, 8'h21, 2'd0, 7);  // R7 reserved code
    sendPacket(2'd1, 1, 8'h80, 8'h00, 2'd2, 5);  // R5 first bit 1
    sendPacket(2'd0, 2, 8'h3F, 8'h00, 2'd2, 5);  // R5 first bit 0, S100 ignores lanes 5:0
    sendPacket(2'd1, 6, 8'h0F, 8'hE3, 2'd3, 2);  // R2 long continuous packet

    repeat (4) @(negedge clkSys);
    // R4 and R2: everything consumed, lines idle
    nChecks++;
    if (expQ.size() != 0 || dsData !== 1'b0 || dsStrobe !== 1'b0) begin
      nFails++;
      $display("FAIL R2: leftover bits act=%0d exp=0, lines act=%b%b exp=00",
               expQ.size(), dsData, dsStrobe);
    end
    doneRun = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule